// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

The block gathers interrupt requests from three source groups (an urgent group of 4 sources, a general group of 17 and a peripheral group of 23) and folds them into one 32-bit status word. Software reads that word to find the winning source in each group. Each group has its own valid flag and source-number field, so the urgent, general and peripheral winners are visible at the same time. The handler reads the urgent field first, then the general field, then the peripheral field.

A 32-channel DMA pending register feeds the peripheral group as that group's source 0. The peripheral group in turn feeds one slot of either the urgent group or the general group, chosen by a control bit. Software walks this chain by number: urgent code 2 or general code 4 points to the peripheral field, and peripheral code 0 points to the DMA pending register.

A small register port holds the mask registers (a set bit disables a source), the DMA pending register (write one to clear), the cascade routing bit and the read-only status word. Request lines are sampled once per clock. The status word is a combinational decode of the sampled requests and the register state.

Top module: `irq_status_encoder`

## Requirements
- R1: After reset the urgent mask reads 0x0000000F, the general mask reads 0x0001FFFF, the peripheral mask reads 0xFFFFFE00, the DMA mask reads 0xFFFFFFFF, the DMA pending register reads 0, the control register reads 0 and the status word reads 0.
- R2: Status bit 10 is set when an urgent source is pending and not masked, and bits 9:8 hold its number. Urgent source i is masked by bit i of the urgent mask (address 0).
- R3: Status bit 21 is set when a general source is pending and not masked, and bits 20:16 hold its number. General source i is masked by bit 16-i of the general mask (address 1).
- R4: Status bit 29 is set when a peripheral source is pending and not masked, and bits 28:24 hold its number. Peripheral source i is masked by bit 31-i of the peripheral mask (address 2).
- R5: Within each group the lowest-numbered unmasked pending source wins. The three fields are encoded independently, so all three can be valid at once.
- R6: When any peripheral source is pending and not masked, it raises general source 4 while control bit 0 (address 5) is 0, or urgent source 2 while that bit is 1. The request inputs at urgent position 2 and general position 4 have no effect.
- R7: Peripheral source 0 is pending whenever the DMA pending register ANDed with the inverse of the DMA mask (address 4, channel i at bit i) is nonzero. Request input peripheral bit 0 has no effect.
- R8: A DMA set input bit sets DMA pending bit i. Writing 1 to bit i at address 3 clears it, and writing 0 leaves it unchanged. A bit that is set and cleared in the same cycle stays set.
- R9: Registers are read at addresses 0 to 6 with unimplemented bits reading 0, and address 7 reads 0. The status word sits at address 6 and ignores writes. Writes take effect at the clock edge where the write strobe is high.
- R10: Request inputs are sampled at each clock edge and show up in the status word after that edge. A field with no winner reads all zeros, valid bit included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 4 | Urgent group request levels |
| main_req_i | input | 17 | General group request levels |
| per_req_i | input | 23 | Peripheral group request levels |
| dma_set_i | input | 32 | DMA channel pending set pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| status_o | output | 32 | Encoded status word |

## Verification
Single-source patterns in each group check the field position, the valid bit and the mask bit mapping. Multi-source patterns tell lowest-number selection apart from highest-number selection. The same patterns, repeated with selected sources masked, show that masking acts on the intended bit of the reversed general and peripheral masks. Peripheral requests under both routing settings, and DMA channels under set, clear and set-with-clear in the same cycle, show the cascade codes and the write-one-to-clear rule. A long random phase with mixed register writes checks that the fields stay independent and consistent with each other.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int CRIT_N    = 4;
  localparam int MAIN_N    = 17;
  localparam int PER_N     = 23;
  localparam int DMA_N     = 32;
  localparam int DW        = 32;
  localparam int AW        = 3;
  localparam int CRIT_IW   = $clog2(CRIT_N);
  localparam int MAIN_IW   = $clog2(MAIN_N);
  localparam int PER_IW    = $clog2(PER_N);
  localparam int PER_LSB   = DW - PER_N;

  // cascade slots
  localparam int CRIT_CASC = 2;
  localparam int MAIN_CASC = 4;
  localparam int PER_DMA   = 0;

  // status field layout (decoded by software)
  localparam int ST_CRIT_V = 10;
  localparam int ST_CRIT_L = 8;
  localparam int ST_MAIN_V = 21;
  localparam int ST_MAIN_L = 16;
  localparam int ST_PER_V  = 29;
  localparam int ST_PER_L  = 24;

  typedef enum logic [AW-1:0] {
    A_CMASK  = 3'd0,
    A_MMASK  = 3'd1,
    A_PMASK  = 3'd2,
    A_DPEND  = 3'd3,
    A_DMASK  = 3'd4,
    A_CTRL   = 3'd5,
    A_STATUS = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/ic_prio_enc.sv
module ic_prio_enc #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] below;

  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  always_comb begin
    below = (N'(1) << idx_o) - N'(1);
    if (valid_o) begin
      AST_ENC_LOWEST: assert (req_i[idx_o] && ((req_i & below) == '0)); // R5
    end
  end
endmodule

// File: rtl/ic_regs.sv
module ic_regs
  import irq_status_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [DMA_N-1:0]    dma_set_i,
  input  logic [DW-1:0]       status_i,
  output logic [DW-1:0]       rdata_o,
  output logic [CRIT_N-1:0]   crit_mask_o,
  output logic [MAIN_N-1:0]   main_mask_o,
  output logic [PER_N-1:0]    per_mask_o,
  output logic [DMA_N-1:0]    dma_mask_o,
  output logic [DMA_N-1:0]    dma_pend_o,
  output logic                route_hi_o
);
  logic [CRIT_N-1:0] crit_mask_q;
  logic [MAIN_N-1:0] main_mask_q;
  logic [PER_N-1:0]  per_mask_q;
  logic [DMA_N-1:0]  dma_mask_q, dma_pend_q, dma_clr;
  logic              route_q, past_ok_q;

  assign dma_clr = (we_i && addr_i == A_DPEND) ? wdata_i[DMA_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_mask_q <= '1;
      main_mask_q <= '1;
      per_mask_q  <= '1;
      dma_mask_q  <= '1;
      dma_pend_q  <= '0;
      route_q     <= 1'b0;
      past_ok_q   <= 1'b0;
    end else begin
      past_ok_q  <= 1'b1;
      dma_pend_q <= (dma_pend_q & ~dma_clr) | dma_set_i;  // set wins
      if (we_i) begin
        unique case (addr_i)
          A_CMASK: crit_mask_q <= wdata_i[CRIT_N-1:0];
          A_MMASK: main_mask_q <= wdata_i[MAIN_N-1:0];
          A_PMASK: per_mask_q  <= wdata_i[DW-1:PER_LSB];
          A_DMASK: dma_mask_q  <= wdata_i[DMA_N-1:0];
          A_CTRL:  route_q     <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMASK:  rdata_o[CRIT_N-1:0]    = crit_mask_q;
      A_MMASK:  rdata_o[MAIN_N-1:0]    = main_mask_q;
      A_PMASK:  rdata_o[DW-1:PER_LSB]  = per_mask_q;
      A_DPEND:  rdata_o[DMA_N-1:0]     = dma_pend_q;
      A_DMASK:  rdata_o[DMA_N-1:0]     = dma_mask_q;
      A_CTRL:   rdata_o[0]             = route_q;
      A_STATUS: rdata_o                = status_i;
      default:  rdata_o                = '0;
    endcase
  end

  assign crit_mask_o = crit_mask_q;
  assign main_mask_o = main_mask_q;
  assign per_mask_o  = per_mask_q;
  assign dma_mask_o  = dma_mask_q;
  assign dma_pend_o  = dma_pend_q;
  assign route_hi_o  = route_q;

  AST_DMA_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(we_i && addr_i == A_DPEND))
      |-> ((dma_pend_q & $past(wdata_i[DMA_N-1:0] & ~dma_set_i)) == '0)); // R8
  AST_DMA_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> ((dma_pend_q & $past(dma_set_i)) == $past(dma_set_i))); // R8
endmodule

// File: rtl/ic_cascade.sv
module ic_cascade
  import irq_status_pkg::*;
(
  input  logic [CRIT_N-1:0] crit_p_i,
  input  logic [MAIN_N-1:0] main_p_i,
  input  logic [PER_N-1:0]  per_p_i,
  input  logic [CRIT_N-1:0] crit_mask_i,
  input  logic [MAIN_N-1:0] main_mask_i,
  input  logic [PER_N-1:0]  per_mask_i,
  input  logic [DMA_N-1:0]  dma_pend_i,
  input  logic [DMA_N-1:0]  dma_mask_i,
  input  logic              route_hi_i,
  output logic [CRIT_N-1:0] crit_eff_o,
  output logic [MAIN_N-1:0] main_eff_o,
  output logic [PER_N-1:0]  per_eff_o
);
  logic dma_any, per_any;

  assign dma_any = |(dma_pend_i & ~dma_mask_i);
  assign per_any = |per_eff_o;

  // peripheral mask is bit-reversed: source i at mask index PER_N-1-i
  for (genvar i = 0; i < PER_N; i++) begin : g_per
    if (i == PER_DMA) begin : g_dma
      assign per_eff_o[i] = dma_any & ~per_mask_i[PER_N-1-i];
    end else begin : g_req
      assign per_eff_o[i] = per_p_i[i] & ~per_mask_i[PER_N-1-i];
    end
  end

  for (genvar i = 0; i < MAIN_N; i++) begin : g_main
    if (i == MAIN_CASC) begin : g_casc
      assign main_eff_o[i] = per_any & ~route_hi_i & ~main_mask_i[MAIN_N-1-i];
    end else begin : g_req
      assign main_eff_o[i] = main_p_i[i] & ~main_mask_i[MAIN_N-1-i];
    end
  end

  for (genvar i = 0; i < CRIT_N; i++) begin : g_crit
    if (i == CRIT_CASC) begin : g_casc
      assign crit_eff_o[i] = per_any & route_hi_i & ~crit_mask_i[i];
    end else begin : g_req
      assign crit_eff_o[i] = crit_p_i[i] & ~crit_mask_i[i];
    end
  end
endmodule

// File: rtl/irq_status_encoder.sv
module irq_status_encoder
  import irq_status_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CRIT_N-1:0]   crit_req_i,
  input  logic [MAIN_N-1:0]   main_req_i,
  input  logic [PER_N-1:0]    per_req_i,
  input  logic [DMA_N-1:0]    dma_set_i,
  input  logic                reg_we_i,
  input  logic [AW-1:0]       reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic [DW-1:0]       status_o
);
  logic [CRIT_N-1:0]  crit_p_q, crit_mask, crit_eff;
  logic [MAIN_N-1:0]  main_p_q, main_mask, main_eff;
  logic [PER_N-1:0]   per_p_q, per_mask, per_eff;
  logic [DMA_N-1:0]   dma_mask, dma_pend;
  logic               route_hi;
  logic               crit_v, main_v, per_v;
  logic [CRIT_IW-1:0] crit_idx;
  logic [MAIN_IW-1:0] main_idx;
  logic [PER_IW-1:0]  per_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_p_q <= '0;
      main_p_q <= '0;
      per_p_q  <= '0;
    end else begin
      crit_p_q <= crit_req_i;
      main_p_q <= main_req_i;
      per_p_q  <= per_req_i;
    end
  end

  ic_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .dma_set_i   (dma_set_i),
    .status_i    (status_o),
    .rdata_o     (reg_rdata_o),
    .crit_mask_o (crit_mask),
    .main_mask_o (main_mask),
    .per_mask_o  (per_mask),
    .dma_mask_o  (dma_mask),
    .dma_pend_o  (dma_pend),
    .route_hi_o  (route_hi)
  );

  ic_cascade u_casc (
    .crit_p_i    (crit_p_q),
    .main_p_i    (main_p_q),
    .per_p_i     (per_p_q),
    .crit_mask_i (crit_mask),
    .main_mask_i (main_mask),
    .per_mask_i  (per_mask),
    .dma_pend_i  (dma_pend),
    .dma_mask_i  (dma_mask),
    .route_hi_i  (route_hi),
    .crit_eff_o  (crit_eff),
    .main_eff_o  (main_eff),
    .per_eff_o   (per_eff)
  );

  ic_prio_enc #(.N(CRIT_N), .IW(CRIT_IW)) u_enc_crit (
    .req_i (crit_eff), .valid_o (crit_v), .idx_o (crit_idx));
  ic_prio_enc #(.N(MAIN_N), .IW(MAIN_IW)) u_enc_main (
    .req_i (main_eff), .valid_o (main_v), .idx_o (main_idx));
  ic_prio_enc #(.N(PER_N), .IW(PER_IW)) u_enc_per (
    .req_i (per_eff), .valid_o (per_v), .idx_o (per_idx));

  always_comb begin
    status_o = '0;
    status_o[ST_CRIT_V]                      = crit_v;
    status_o[ST_CRIT_L +: CRIT_IW]           = crit_idx;
    status_o[ST_MAIN_V]                      = main_v;
    status_o[ST_MAIN_L +: MAIN_IW]           = main_idx;
    status_o[ST_PER_V]                       = per_v;
    status_o[ST_PER_L +: PER_IW]             = per_idx;
  end

  AST_CASC_TO_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_PER_V] && !route_hi && !main_mask[MAIN_N-1-MAIN_CASC])
      |-> status_o[ST_MAIN_V]); // R6
  AST_CASC_TO_CRIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_PER_V] && route_hi && !crit_mask[CRIT_CASC])
      |-> status_o[ST_CRIT_V]); // R6
  AST_DMA_CASC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(dma_pend & ~dma_mask)) && !per_mask[PER_N-1-PER_DMA])
      |-> (status_o[ST_PER_V] && status_o[ST_PER_L +: PER_IW] == '0)); // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[ST_CRIT_V] |-> status_o[ST_CRIT_L +: CRIT_IW] == '0) and
    (!status_o[ST_MAIN_V] |-> status_o[ST_MAIN_L +: MAIN_IW] == '0) and
    (!status_o[ST_PER_V]  |-> status_o[ST_PER_L +: PER_IW] == '0)); // R10
endmodule

// File: tb/irq_status_encoder_test.sv
`timescale 1ns/1ps
module irq_status_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [22:0] per_req = '0;
  logic [31:0] dma_set = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur = "R1";

  // reference state
  logic [3:0]  m_crit = '0;
  logic [16:0] m_main = '0;
  logic [22:0] m_per = '0;
  logic [31:0] m_cmask = 32'h0000000F, m_mmask = 32'h0001FFFF, m_pmask = 32'hFFFFFE00;
  logic [31:0] m_dmask = 32'hFFFFFFFF, m_dpend = '0;
  bit          m_route = 0;

  always #2 clk = ~clk;

  irq_status_encoder uut (
    .clk_i (clk), .rst_ni (rst_n), .crit_req_i (crit_req), .main_req_i (main_req),
    .per_req_i (per_req), .dma_set_i (dma_set), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .status_o (status));

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    int pw = -1, mw = -1, cw = -1;
    bit per_any = 0;
    for (int i = 0; i < 23; i++) begin
      bit r = (i == 0) ? ((m_dpend & ~m_dmask) != 0) : m_per[i];
      if (r && !m_pmask[31-i]) begin per_any = 1; if (pw < 0) pw = i; end
    end
    for (int i = 0; i < 17; i++) begin
      bit r = (i == 4) ? (per_any && !m_route) : m_main[i];
      if (r && !m_mmask[16-i] && mw < 0) mw = i;
    end
    for (int i = 0; i < 4; i++) begin
      bit r = (i == 2) ? (per_any && m_route) : m_crit[i];
      if (r && !m_cmask[i] && cw < 0) cw = i;
    end
    if (cw >= 0) begin s[10] = 1; s[9:8]   = cw[1:0]; end
    if (mw >= 0) begin s[21] = 1; s[20:16] = mw[4:0]; end
    if (pw >= 0) begin s[29] = 1; s[28:24] = pw[4:0]; end
    return s;
  endfunction

  function automatic logic [31:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return m_cmask;
      3'd1: return m_mmask;
      3'd2: return m_pmask;
      3'd3: return m_dpend;
      3'd4: return m_dmask;
      3'd5: return {31'd0, m_route};
      3'd6: return exp_status();
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit w, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    @(posedge clk);
    if (w) begin
      case (a)
        3'd0: m_cmask = d & 32'h0000000F;
        3'd1: m_mmask = d & 32'h0001FFFF;
        3'd2: m_pmask = d & 32'hFFFFFE00;
        3'd4: m_dmask = d;
        3'd5: m_route = d[0];
        default: ;
      endcase
    end
    m_dpend = (m_dpend & ~((w && a == 3'd3) ? d : 32'd0)) | dma_set;
    m_crit = crit_req; m_main = main_req; m_per = per_req;
    #1;
    chk(cur, "status", status, exp_status());
    chk(cur, "rdata", rdata, exp_rdata(a));
  endtask

  task automatic rd(logic [2:0] a); cyc(0, a, 32'd0); endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0;
    // R1 reset values
    cur = "R1";
    for (int a = 0; a < 8; a++) rd(3'(a));

    // R9 register map, unimplemented bits read 0, status ignores writes
    cur = "R9";
    cyc(1, 3'd1, 32'hFFFFFFFF); rd(3'd1);
    cyc(1, 3'd0, 32'hFFFFFFF5); rd(3'd0);
    cyc(1, 3'd6, 32'hFFFFFFFF); rd(3'd6); rd(3'd7);
    cyc(1, 3'd5, 32'hFFFFFFFE); rd(3'd5);

    // unmask everything
    cyc(1, 3'd0, 0); cyc(1, 3'd1, 0); cyc(1, 3'd2, 0); cyc(1, 3'd4, 0);

    // R2 urgent field
    cur = "R2";
    crit_req = 4'b1010; rd(3'd6); rd(3'd6);
    crit_req = 4'b1000; rd(3'd6); rd(3'd6);
    crit_req = 4'b1011; cyc(1, 3'd0, 32'h1); rd(3'd6);
    cyc(1, 3'd0, 32'h0);
    // R10 sampling delay and empty fields
    cur = "R10";
    crit_req = 4'b0000; rd(3'd6); rd(3'd6);

    // R3 general field with reversed mask
    cur = "R3";
    main_req = 17'h10000; rd(3'd6); rd(3'd6);
    main_req = 17'h00088; rd(3'd6); rd(3'd6);
    cyc(1, 3'd1, 32'h1 << 13); rd(3'd6);
    cyc(1, 3'd1, 32'h0); main_req = '0; rd(3'd6);

    // R4 peripheral field with reversed mask
    cur = "R4";
    per_req = 23'h400000; rd(3'd6); rd(3'd6);
    per_req = 23'h000220; rd(3'd6); rd(3'd6);
    cyc(1, 3'd2, 32'h1 << 26); rd(3'd6);
    cyc(1, 3'd2, 32'h0); rd(3'd6);

    // R6 cascade routing, ignored inputs at cascade slots
    cur = "R6";
    per_req = 23'h000100; main_req = 17'h00010; crit_req = 4'b0100; rd(3'd6); rd(3'd6);
    cyc(1, 3'd5, 32'h1); rd(3'd6);
    per_req = '0; rd(3'd6); rd(3'd6);
    cyc(1, 3'd5, 32'h0); main_req = '0; crit_req = '0; rd(3'd6);

    // R7 DMA cascade
    cur = "R7";
    per_req = 23'h000001; rd(3'd6); rd(3'd6);
    per_req = '0;
    dma_set = 32'h00000080; rd(3'd3); dma_set = '0; rd(3'd6);
    cyc(1, 3'd4, 32'h00000080); rd(3'd6);
    cyc(1, 3'd4, 32'h0); rd(3'd6);

    // R8 pending set/clear rules
    cur = "R8";
    cyc(1, 3'd3, 32'h0); rd(3'd3);
    cyc(1, 3'd3, 32'h00000080); rd(3'd3);
    dma_set = 32'h80000001; rd(3'd3); dma_set = 32'h00000001;
    cyc(1, 3'd3, 32'h80000001); dma_set = '0; rd(3'd3);
    cyc(1, 3'd3, 32'hFFFFFFFF); rd(3'd3);

    // R5 lowest wins, all fields at once
    cur = "R5";
    crit_req = 4'b1001; main_req = 17'h1_0040; per_req = 23'h7F0000; rd(3'd6); rd(3'd6);
    for (int k = 0; k < 1500; k++) begin
      crit_req = 4'($urandom); main_req = 17'($urandom); per_req = 23'($urandom);
      dma_set = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'd0;
      if ($urandom % 8 == 0) cyc(1, 3'($urandom % 8), ($urandom % 2) ? $urandom : $urandom & $urandom);
      else rd(3'($urandom % 8));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule